// File: doc/BRIEF.md
# Multi-Format Palette Lookup

This block is a 256-entry colour lookup table for a display pipeline. Software fills the entries through a simple register write port. Each entry is a 32-bit word written at a fixed palette base address plus four bytes per entry. A separate format register says how the stored words are to be read.

On the display side, a pixel index goes in and an expanded 32-bit ARGB colour with 8 bits per channel comes out one clock later. Entries are stored raw. The format register is applied at the output, so changing the format reinterprets the whole table without rewriting it. Channels narrower than 8 bits are widened by copying their top bits into the low bits. This maps the field maximum to 0xFF and zero to 0x00.

Top module: `palette_lut`

## Requirements
- R1: After reset the format register holds 0 (ARGB1555), and `argb_out` is 0x00000000 until the first index is looked up.
- R2: A write to byte address 0x0108 loads `reg_wdata[1:0]` into the format register, with 0=ARGB1555, 1=RGB565, 2=ARGB4444 and 3=ARGB8888. All other data bits are ignored.
- R3: A write to byte address 0x1000 + 4·n (n from 0 to 255) stores all 32 bits of `reg_wdata` as entry n. A write to any other address is ignored, including unaligned addresses inside the palette range and 0x1400 and above.
- R4: An index presented at a rising edge produces its colour on `argb_out` right after that edge, and the output holds until the next edge.
- R5: In ARGB8888 the output is the stored word unchanged: alpha in bits 31:24, red in 23:16, green in 15:8 and blue in 7:0.
- R6: In RGB565, red is read from bits 15:11, green from 10:5 and blue from 4:0, and alpha is output as 0xFF. A 5-bit value v expands to {v, v[4:2]} and a 6-bit value g expands to {g, g[5:4]}.
- R7: In ARGB1555, alpha is bit 15 and expands to 0x00 or 0xFF. Red is bits 14:10, green bits 9:5 and blue bits 4:0, each expanded as in R6.
- R8: In ARGB4444, alpha, red, green and blue are the nibbles 15:12, 11:8, 7:4 and 3:0. Each nibble expands to itself repeated twice.
- R9: When an entry is written at the same edge that its index is looked up, the output after that edge shows the newly written value.
- R10: A format change takes effect on `argb_out` right after the edge that writes the format register, and is applied to the entry already looked up.
- R11: The output occupies all 32 bits: alpha in 31:24, red in 23:16, green in 15:8 and blue in 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 13 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| pix_idx | input | 8 | Pixel index to look up |
| argb_out | output | 32 | Expanded ARGB colour |

## Verification
Lookup results fall due one edge after the index is presented. Same-edge write bypass (R9) and format changes (R10) are also visible immediately after the edge that carries them. Register writes need no extra wait before a lookup may use them. The bench drives all inputs on the falling edge and samples `argb_out` on the following falling edge. Every comparison is therefore made half a cycle after exactly one rising edge. The expected colour comes from a bench model of the table and a decoding function written from the field layouts.

// File: rtl/palette_lut.sv
module palette_lut #(
  parameter int ENTRIES   = 256,
  parameter int ADDR_W    = 13,
  parameter int PAL_BASE  = 'h1000,
  parameter int FMT_ADDR  = 'h0108
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  input  logic [$clog2(ENTRIES)-1:0] pix_idx,
  output logic [31:0]                argb_out
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(PAL_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(ENTRIES * 4);
  localparam logic [ADDR_W-1:0] FMT_A  = ADDR_W'(FMT_ADDR);

  logic [31:0]      table_q [ENTRIES];
  logic [31:0]      word_q;
  logic [1:0]       fmt_q;
  logic [ADDR_W-1:0] ofs;
  logic             ent_we;
  logic [IDX_W-1:0] ent_idx;

  assign ofs     = reg_addr - BASE_A;
  assign ent_we  = reg_we && (ofs < SPAN_A) && (ofs[1:0] == 2'b00);
  assign ent_idx = ofs[IDX_W+1:2];

  always_ff @(posedge clk) begin
    if (ent_we) table_q[ent_idx] <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      fmt_q  <= 2'd0;
    end else begin
      word_q <= (ent_we && ent_idx == pix_idx) ? reg_wdata : table_q[pix_idx];
      if (reg_we && reg_addr == FMT_A) fmt_q <= reg_wdata[1:0];
    end
  end

  logic [15:0] h;
  assign h = word_q[15:0];

  always_comb begin
    unique case (fmt_q)
      2'd0: argb_out = {{8{h[15]}},
                        h[14:10], h[14:12],
                        h[9:5],   h[9:7],
                        h[4:0],   h[4:2]};
      2'd1: argb_out = {8'hFF,
                        h[15:11], h[15:13],
                        h[10:5],  h[10:9],
                        h[4:0],   h[4:2]};
      2'd2: argb_out = {h[15:12], h[15:12], h[11:8], h[11:8],
                        h[7:4],   h[7:4],   h[3:0],  h[3:0]};
      default: argb_out = word_q;
    endcase
  end
endmodule

// File: rtl/palette_lut_chk.sv
module palette_lut_chk #(
  parameter int ADDR_W   = 13,
  parameter int IDX_W    = 8,
  parameter int ENTRIES  = 256,
  parameter int PAL_BASE = 'h1000,
  parameter int FMT_ADDR = 'h0108
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [IDX_W-1:0]  pix_idx,
  input logic [31:0]       argb_out,
  input logic [1:0]        fmt_q
);
  logic fmt_wr, same_wr;
  assign fmt_wr  = reg_we && (reg_addr == ADDR_W'(FMT_ADDR));
  assign same_wr = reg_we && (reg_addr == ADDR_W'(PAL_BASE + 4 * int'(pix_idx)));

  assert_fmt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_wr |=> fmt_q == $past(reg_wdata[1:0]));

  assert_alpha_binary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_q == 2'd0 |-> (argb_out[31:24] == 8'h00 || argb_out[31:24] == 8'hFF));

  assert_opaque_565_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_q == 2'd1 |-> argb_out[31:24] == 8'hFF && argb_out[2:0] == argb_out[7:5]);

  assert_nibble_rep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_q == 2'd2 |-> argb_out[31:28] == argb_out[27:24] && argb_out[3:0] == argb_out[7:4]);

  assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (same_wr && fmt_q == 2'd3 && !fmt_wr) |=> argb_out == $past(reg_wdata));
endmodule

bind palette_lut palette_lut_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENTRIES(ENTRIES),
  .PAL_BASE(PAL_BASE), .FMT_ADDR(FMT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pix_idx(pix_idx), .argb_out(argb_out), .fmt_q(fmt_q)
);

// File: tb/tb_palette_lut.sv
module tb_palette_lut;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [12:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [7:0]  pix_idx = '0;
  logic [31:0] argb_out;

  int n_chk = 0, n_bad = 0;
  logic [31:0] model [256];
  logic [1:0]  cur_fmt;
  bit finished = 0;

  palette_lut dut (.*);

  always #5 clk = ~clk;

  function automatic logic [7:0] wid(input logic [7:0] v, input int bits);
    logic [7:0] r;
    r = v << (8 - bits);
    for (int s = bits; s < 8; s += bits) r = r | (r >> s);
    return r;
  endfunction

  function automatic logic [31:0] expect_col(input logic [1:0] f, input logic [31:0] w);
    case (f)
      2'd3: return w;
      2'd1: return {8'hFF, wid(8'(w[15:11]), 5), wid(8'(w[10:5]), 6), wid(8'(w[4:0]), 5)};
      2'd0: return {(w[15] ? 8'hFF : 8'h00), wid(8'(w[14:10]), 5),
                    wid(8'(w[9:5]), 5), wid(8'(w[4:0]), 5)};
      default: return {wid(8'(w[15:12]), 4), wid(8'(w[11:8]), 4),
                       wid(8'(w[7:4]), 4), wid(8'(w[3:0]), 4)};
    endcase
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] exp);
    n_chk++;
    if (argb_out !== exp) begin
      n_bad++;
      $display("FAIL %s: argb_out=%08h expected=%08h", req, argb_out, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic set_fmt(input logic [1:0] f);
    wr(13'h0108, {$urandom, 2'b00} | 32'(f));
    cur_fmt = f;
  endtask

  task automatic look(input string req, input logic [7:0] i);
    pix_idx = i;
    tick();
    check(req, expect_col(cur_fmt, model[i]));
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    @(negedge clk); tick(); tick();
    rst_n = 1;
    check("R1", 32'h0);
    cur_fmt = 2'd0;
    for (int i = 0; i < 256; i++) begin
      model[i] = $urandom;
      wr(13'h1000 + 13'(4 * i), model[i]);
    end
    // R1 default format is ARGB1555
    look("R1", 8'd7);
    // directed corner words, R11 field placement
    model[1] = 32'h0000_FFFF; wr(13'h1004, model[1]);
    model[2] = 32'h1234_8000; wr(13'h1008, model[2]);
    model[3] = 32'hA5C3_7C1F; wr(13'h100C, model[3]);
    for (int f = 0; f < 4; f++) begin
      set_fmt(2'(f));
      look("R11", 8'd1); look("R11", 8'd2); look("R11", 8'd3);
    end
    set_fmt(2'd3);
    pix_idx = 8'd255; tick(); check("R5", model[255]);
    // R4 output holds between edges
    #3 check("R4", model[255]);
    @(negedge clk);
    // random lookups, every format
    for (int f = 0; f < 4; f++) begin
      set_fmt(2'(f));
      for (int k = 0; k < 40; k++) begin
        case (f)
          0: look("R7", 8'($urandom));
          1: look("R6", 8'($urandom));
          2: look("R8", 8'($urandom));
          default: look("R5", 8'($urandom));
        endcase
      end
    end
    // R3 ignored writes: unaligned, past end, below base
    set_fmt(2'd3);
    wr(13'h1001, 32'hDEAD_0001);
    wr(13'h1402, 32'hDEAD_0002);
    wr(13'h1400, 32'hDEAD_0003);
    wr(13'h0FFC, 32'hDEAD_0004);
    look("R3", 8'd0);
    look("R3", 8'd255);
    wr(13'h13FC, 32'h0BAD_CAFE); model[255] = 32'h0BAD_CAFE;
    look("R3", 8'd255);
    // R2 format register ignores upper bits; other address does not change it
    wr(13'h010C, 32'h0000_0000);
    look("R2", 8'd3);
    // R9 same-edge write and lookup
    pix_idx = 8'd42; reg_we = 1; reg_addr = 13'h1000 + 13'd168; reg_wdata = 32'h1357_9BDF;
    model[42] = 32'h1357_9BDF;
    tick(); reg_we = 0;
    check("R9", 32'h1357_9BDF);
    // R10 format change applies to already-fetched entry
    cur_fmt = 2'd2;
    reg_we = 1; reg_addr = 13'h0108; reg_wdata = 32'h2;
    tick(); reg_we = 0;
    check("R10", expect_col(2'd2, model[42]));
    cur_fmt = 2'd1;
    reg_we = 1; reg_addr = 13'h0108; reg_wdata = 32'hFFFF_FFF1;
    tick(); reg_we = 0;
    check("R10", expect_col(2'd1, model[42]));
    // R1 reset again
    rst_n = 0; tick(); rst_n = 1;
    check("R1", 32'h0);
    cur_fmt = 2'd0;
    look("R1", 8'd42);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule